// File: doc/BRIEF.md
# Multi-Pattern Wake Frame Matcher

This block watches a received frame, delivered one 32-bit dword per cycle with start and end markers, and checks it against as many as eight wake patterns held in a 64-entry, 40-bit pattern array. Each pattern is a chain of array words. The chain starts at a pointer taken from the two header words. Every word in the chain carries its own control byte: a last-word flag, a count of frame dwords to pass over before the word is compared, and a per-byte care mask. All enabled patterns follow the same frame in parallel. Each pattern has its own tracker and its own combinational read port into the array.

When any pattern reaches its last word with every cared-for byte equal, the block raises a one-cycle per-pattern hit. The hit sets a sticky detect flag. The detect flag then sets a sticky power-management status bit. The wake output is high while that status bit and the wake enable are both set. Software clears each flag by pulsing its clear input. The array is written elsewhere. This block only reads it: ports 0 to 7 serve the pattern trackers, and ports 8 and 9 are fixed on header words 0 and 1.

Top module: `wake_pattern_matcher`

## Requirements
- R1: Pattern n is tracked only if bit n of header word 0 bits [7:0] is set. The enable is sampled on the start-of-frame dword, and a disabled pattern never hits.
- R2: The start pointer of pattern n (n<4) is header word 0 bits [8n+15:8n+8]. For pattern n>=4 it is header word 1 bits [8(n-4)+15:8(n-4)+8]. Only the low 6 bits of a pointer form the word address.
- R3: In an array word, bits [7:0] are control and bits [8k+15:8k+8] are pattern byte k, compared with frame byte lane rx_data[8k+7:8k]. Control bits [3:0] are the care mask for bytes 3:0, and a mask bit of 0 makes that byte a don't-care.
- R4: Control bits [6:4] give how many frame dwords (0 to 7) are passed over before the word is compared.
- R5: A compared word that agrees moves the pattern to the next array address, or, if control bit 7 (last word) is set, makes hit_pulse[n] high for the single cycle after that dword. A disagreeing word abandons the pattern for the rest of the frame.
- R6: A frame whose end-of-frame dword arrives before a pattern's last word has agreed gives no hit for that pattern. Every start of frame restarts each pattern at its pointer.
- R7: Dwords count only when rx_valid is 1 and match_mode_en, rx_run and rx_suspend are all 1. If any of those three is 0, all trackers are idle and no hit occurs.
- R8: det_flag goes to 1 on the cycle after any hit_pulse bit is 1. It stays set until det_clr is 1, and a new hit wins over a clear.
- R9: pm_status goes to 1 on the cycle after det_flag is 1, and it stays set until pm_clr is 1 at a time when det_flag is 0.
- R10: wake_out is 1 exactly when pm_status and wake_en are both 1.
- R11: After reset, hit_pulse, det_flag, pm_status and wake_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_mode_en | input | 1 | Pattern matching mode enable |
| rx_run | input | 1 | Receive run control |
| rx_suspend | input | 1 | Receive suspend control |
| wake_en | input | 1 | Allows pm_status to drive wake_out |
| rx_valid | input | 1 | rx_data holds a frame dword |
| rx_sof | input | 1 | Current dword is the first of the frame |
| rx_eof | input | 1 | Current dword is the last of the frame |
| rx_data | input | 32 | Frame dword, lane 0 = earliest byte |
| rd_addr | output | 60 | Ten 6-bit array read addresses (8 trackers, then words 0 and 1) |
| rd_data | input | 400 | Ten 40-bit array words, returned combinationally |
| det_clr | input | 1 | Clears det_flag (write one to clear) |
| pm_clr | input | 1 | Clears pm_status (write one to clear) |
| hit_pulse | output | 8 | Per-pattern one-cycle full-match pulse |
| det_flag | output | 1 | Sticky pattern-detect flag |
| pm_status | output | 1 | Sticky power-management status |
| wake_out | output | 1 | Wake request |

## Verification
The assertions assume that every frame begins with a dword that has rx_sof set, that rx_sof and rx_eof appear only with rx_valid, and that the array words answer in the same cycle they are addressed. The bench follows these rules. It drives one dword per valid cycle, marks the start and end of each frame, and holds all control inputs steady while a frame is in flight. The array contents change only between frames, so every tracker reads a settled word. The bench also assumes that det_clr and pm_clr are short pulses, and it clears det_flag before pm_status so that the order of the sticky bits stays observable.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
    localparam int WORD_W  = 40;
    localparam int ADDR_W  = 6;
    localparam int LANES   = 4;
    localparam int BYTE_W  = 8;
    localparam int DWORD_W = LANES * BYTE_W;
    localparam int MAX_PAT = 8;
    localparam int SKIP_W  = 3;

    typedef struct packed {
        logic              last;
        logic [SKIP_W-1:0] skip;
        logic [LANES-1:0]  care;
    } ctrl_t;

    typedef struct packed {
        logic [DWORD_W-1:0] bytes;
        ctrl_t              ctrl;
    } pword_t;

    typedef enum logic {
        TR_OFF = 1'b0,
        TR_ON  = 1'b1
    } tr_state_t;

    function automatic logic lanes_agree(pword_t w, logic [DWORD_W-1:0] d);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (w.ctrl.care[k] && (w.bytes[k*BYTE_W +: BYTE_W] != d[k*BYTE_W +: BYTE_W]))
                ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/wpm_header.sv
module wpm_header
    import wpm_pkg::*;
#(
    parameter int NPAT = MAX_PAT
) (
    input  logic [WORD_W-1:0]      hdr0,
    input  logic [WORD_W-1:0]      hdr1,
    output logic [NPAT-1:0]        pat_en,
    output logic [NPAT*ADDR_W-1:0] pat_ptr
);
    localparam int HALF = MAX_PAT / 2;

    logic [MAX_PAT*BYTE_W-1:0] raw_ptr;

    assign pat_en = hdr0[NPAT-1:0];

    for (genvar p = 0; p < MAX_PAT; p++) begin : g_ptr
        if (p < HALF) begin : g_lo
            assign raw_ptr[p*BYTE_W +: BYTE_W] = hdr0[(p+1)*BYTE_W +: BYTE_W];
        end else begin : g_hi
            assign raw_ptr[p*BYTE_W +: BYTE_W] = hdr1[(p-HALF+1)*BYTE_W +: BYTE_W];
        end
    end

    for (genvar p = 0; p < NPAT; p++) begin : g_trim
        assign pat_ptr[p*ADDR_W +: ADDR_W] = raw_ptr[p*BYTE_W +: ADDR_W];
    end

    logic unused_hdr;
    assign unused_hdr = ^{hdr1[BYTE_W-1:0], hdr0[BYTE_W-1:NPAT > 7 ? 7 : NPAT], raw_ptr};
endmodule

// File: rtl/wpm_tracker.sv
module wpm_tracker
    import wpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               step,
    input  logic               sof,
    input  logic               eof,
    input  logic [DWORD_W-1:0] rx_data,
    input  logic               pat_en,
    input  logic [ADDR_W-1:0]  start_ptr,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0]  rd_word,
    output logic               hit
);
    tr_state_t         st;
    logic [ADDR_W-1:0] cur;
    logic [SKIP_W-1:0] held;

    pword_t            w;
    logic              live;
    logic [ADDR_W-1:0] addr_e;
    logic [SKIP_W-1:0] held_e;
    logic              waiting;
    logic              agree;

    assign w       = pword_t'(rd_word);
    assign live    = sof ? pat_en : (st == TR_ON);
    assign addr_e  = sof ? start_ptr : cur;
    assign held_e  = sof ? '0 : held;
    assign rd_addr = addr_e;
    assign waiting = held_e < w.ctrl.skip;
    assign agree   = lanes_agree(w, rx_data);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st   <= TR_OFF;
            hit  <= 1'b0;
            cur  <= '0;
            held <= '0;
        end else begin
            hit <= 1'b0;
            if (step) begin
                st <= TR_OFF;
                if (live) begin
                    if (waiting) begin
                        cur  <= addr_e;
                        held <= held_e + 1'b1;
                        if (!eof) st <= TR_ON;
                    end else if (agree) begin
                        if (w.ctrl.last) begin
                            hit <= 1'b1;
                        end else begin
                            cur  <= addr_e + 1'b1;
                            held <= '0;
                            if (!eof) st <= TR_ON;
                        end
                    end
                end
            end
        end
    end

    p_hit_after_step_r5: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(step));

    p_mismatch_abandons_r5: assert property (@(posedge clk) disable iff (rst)
        (run && step && live && !waiting && !agree) |=> (st == TR_OFF && !hit));

    p_eof_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (step && eof) |=> (st == TR_OFF));

    p_gated_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (st == TR_OFF && !hit));
endmodule

// File: rtl/wpm_status.sv
module wpm_status (
    input  logic clk,
    input  logic rst,
    input  logic any_hit,
    input  logic det_clr,
    input  logic pm_clr,
    input  logic wake_en,
    output logic det_flag,
    output logic pm_status,
    output logic wake_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            det_flag  <= 1'b0;
            pm_status <= 1'b0;
        end else begin
            det_flag  <= any_hit  | (det_flag  & ~det_clr);
            pm_status <= det_flag | (pm_status & ~pm_clr);
        end
    end

    assign wake_out = pm_status & wake_en;

    p_det_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (det_flag && !det_clr) |=> det_flag);

    p_det_source_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(det_flag) |-> $past(any_hit));

    p_pm_source_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(pm_status) |-> $past(det_flag));

    p_pm_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (pm_status && !pm_clr) |=> pm_status);
endmodule

// File: rtl/wake_pattern_matcher.sv
module wake_pattern_matcher
    import wpm_pkg::*;
#(
    parameter int NPAT = MAX_PAT
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             match_mode_en,
    input  logic                             rx_run,
    input  logic                             rx_suspend,
    input  logic                             wake_en,
    input  logic                             rx_valid,
    input  logic                             rx_sof,
    input  logic                             rx_eof,
    input  logic [DWORD_W-1:0]               rx_data,
    output logic [(NPAT+2)*ADDR_W-1:0]       rd_addr,
    input  logic [(NPAT+2)*WORD_W-1:0]       rd_data,
    input  logic                             det_clr,
    input  logic                             pm_clr,
    output logic [NPAT-1:0]                  hit_pulse,
    output logic                             det_flag,
    output logic                             pm_status,
    output logic                             wake_out
);
    localparam int HDR0_PORT = NPAT;
    localparam int HDR1_PORT = NPAT + 1;

    logic                   run;
    logic                   step;
    logic [NPAT-1:0]        pat_en;
    logic [NPAT*ADDR_W-1:0] pat_ptr;

    assign run  = match_mode_en & rx_run & rx_suspend;
    assign step = run & rx_valid;

    assign rd_addr[HDR0_PORT*ADDR_W +: ADDR_W] = ADDR_W'(0);
    assign rd_addr[HDR1_PORT*ADDR_W +: ADDR_W] = ADDR_W'(1);

    wpm_header #(.NPAT(NPAT)) u_header (
        .hdr0    (rd_data[HDR0_PORT*WORD_W +: WORD_W]),
        .hdr1    (rd_data[HDR1_PORT*WORD_W +: WORD_W]),
        .pat_en  (pat_en),
        .pat_ptr (pat_ptr)
    );

    for (genvar p = 0; p < NPAT; p++) begin : g_trk
        wpm_tracker u_trk (
            .clk       (clk),
            .rst       (rst),
            .run       (run),
            .step      (step),
            .sof       (rx_sof),
            .eof       (rx_eof),
            .rx_data   (rx_data),
            .pat_en    (pat_en[p]),
            .start_ptr (pat_ptr[p*ADDR_W +: ADDR_W]),
            .rd_addr   (rd_addr[p*ADDR_W +: ADDR_W]),
            .rd_word   (rd_data[p*WORD_W +: WORD_W]),
            .hit       (hit_pulse[p])
        );
    end

    wpm_status u_status (
        .clk       (clk),
        .rst       (rst),
        .any_hit   (|hit_pulse),
        .det_clr   (det_clr),
        .pm_clr    (pm_clr),
        .wake_en   (wake_en),
        .det_flag  (det_flag),
        .pm_status (pm_status),
        .wake_out  (wake_out)
    );

    p_wake_needs_status_r10: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> (pm_status && wake_en));

    p_reset_quiet_r11: assert property (@(posedge clk)
        $past(rst) |-> (hit_pulse == '0 && !det_flag && !pm_status));
endmodule

// File: tb/wake_pattern_matcher_test.sv
module wake_pattern_matcher_test;
    localparam int NP = 8;
    localparam int AW = 6;
    localparam int WW = 40;
    localparam int NPORT = NP + 2;

    logic clk, rst;
    logic match_mode_en, rx_run, rx_suspend, wake_en;
    logic rx_valid, rx_sof, rx_eof;
    logic [31:0] rx_data;
    logic [NPORT*AW-1:0] rd_addr;
    logic [NPORT*WW-1:0] rd_data;
    logic det_clr, pm_clr;
    logic [NP-1:0] hit_pulse;
    logic det_flag, pm_status, wake_out;

    wake_pattern_matcher uut (
        .clk(clk), .rst(rst), .match_mode_en(match_mode_en), .rx_run(rx_run),
        .rx_suspend(rx_suspend), .wake_en(wake_en), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .det_clr(det_clr), .pm_clr(pm_clr),
        .hit_pulse(hit_pulse), .det_flag(det_flag), .pm_status(pm_status),
        .wake_out(wake_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    logic [39:0] mem [64];
    always_comb begin
        for (int i = 0; i < NPORT; i++)
            rd_data[i*WW +: WW] = mem[rd_addr[i*AW +: AW]];
    end

    typedef struct {
        logic [7:0] mask;
        string      tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] frm[$];
    logic [7:0]  acc;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected hit mask for the frame in frm, built from the requirement text.
    function automatic logic [7:0] predict();
        logic [7:0] m;
        m = '0;
        if (!(match_mode_en && rx_run && rx_suspend)) return m;
        for (int p = 0; p < NP; p++) begin
            logic [7:0] ptr;
            logic [5:0] a;
            int         passed;
            bit         alive;
            alive  = mem[0][p];
            ptr    = (p < 4) ? mem[0][8*(p+1) +: 8] : mem[1][8*(p-3) +: 8];
            a      = ptr[5:0];
            passed = 0;
            foreach (frm[i]) begin
                if (alive) begin
                    logic [39:0] w;
                    bit          same;
                    w = mem[a];
                    if (passed < int'(w[6:4])) begin
                        passed++;
                    end else begin
                        same = 1;
                        for (int k = 0; k < 4; k++)
                            if (w[k] && (w[8*k+8 +: 8] != frm[i][8*k +: 8])) same = 0;
                        if (!same) alive = 0;
                        else if (w[7]) begin m[p] = 1'b1; alive = 0; end
                        else begin a = a + 6'd1; passed = 0; end
                    end
                end
            end
        end
        return m;
    endfunction

    task automatic send_frame(string tag, bit gaps);
        exp_t e;
        e.mask = predict();
        e.tag  = tag;
        foreach (frm[i]) begin
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == frm.size() - 1);
            rx_data  = frm[i];
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
            if (gaps) @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (2) @(negedge clk);
        sb.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: gathers hit pulses and scores them against the queue.
    always @(negedge clk) begin
        if (rst) acc = '0;
        else begin
            acc = acc | hit_pulse;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, {24'h0, acc}, {24'h0, e.mask});
                acc = '0;
            end
        end
    end

    task automatic load_frame1(logic [31:0] last);
        frm = {32'hDDCCBBAA, 32'h00000055, 32'h12345678, last};
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[0] = {8'h00, 8'h06, 8'h05, 8'h02, 8'h25};
        mem[1] = {8'h00, 8'h00, 8'hC8, 8'h00, 8'h00};
        mem[2] = {8'hDD, 8'hCC, 8'hBB, 8'hAA, 8'h0F};
        mem[3] = {8'h99, 8'h88, 8'h22, 8'h11, 8'hA3};
        mem[5] = {32'h0, 8'h80};
        mem[6] = {24'h0, 8'h55, 8'h91};
        mem[8] = {8'h04, 8'h03, 8'h02, 8'h01, 8'h8F};

        rst = 1'b1; match_mode_en = 1'b1; rx_run = 1'b1; rx_suspend = 1'b1;
        wake_en = 1'b1; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_data = '0; det_clr = 1'b0; pm_clr = 1'b0; acc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 hit_pulse", {24'h0, hit_pulse}, 32'h0);
        chk("R11 det_flag", {31'h0, det_flag}, 32'h0);
        chk("R11 pm_status", {31'h0, pm_status}, 32'h0);
        chk("R11 wake_out", {31'h0, wake_out}, 32'h0);

        load_frame1(32'h77772211);
        send_frame("R3 R4 R5 chained match with skip and masked high bytes", 0);
        load_frame1(32'h00002211);
        send_frame("R3 don't-care bytes changed", 0);
        frm = {32'hDDCCBBAB, 32'h00000055, 32'h12345678, 32'h00002211};
        send_frame("R5 cared byte mismatch abandons pattern", 0);
        load_frame1(32'h00002311);
        send_frame("R5 mismatch in last word", 0);
        frm = {32'hDDCCBBAA, 32'h00000000};
        send_frame("R6 frame ends before last word", 0);
        frm = {32'h04030201};
        send_frame("R2 R1 upper pointer with high bits set, disabled pattern silent", 0);
        load_frame1(32'h00002211);
        send_frame("R7 idle cycles between dwords", 1);
        rx_suspend = 1'b0;
        load_frame1(32'h00002211);
        send_frame("R7 gated by suspend control", 0);
        rx_suspend = 1'b1;
        match_mode_en = 1'b0;
        frm = {32'h04030201};
        send_frame("R7 gated by mode enable", 0);
        match_mode_en = 1'b1;
        mem[0][7:0] = 8'h27;
        frm = {32'h04030201};
        send_frame("R1 newly enabled pattern hits", 0);
        frm = {32'h0BADF00D, 32'h04030201};
        send_frame("R6 R2 restart at pointer each frame", 0);
        mem[0][7:0] = 8'h25;

        // Flag timing: clear both sticky bits, then one hitting dword.
        det_clr = 1'b1; @(negedge clk); det_clr = 1'b0;
        pm_clr = 1'b1;  @(negedge clk); pm_clr = 1'b0;
        chk("R8 det cleared", {31'h0, det_flag}, 32'h0);
        chk("R9 pm cleared", {31'h0, pm_status}, 32'h0);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 32'h04030201;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        chk("R5 hit pulse after dword", {31'h0, hit_pulse[5]}, 32'h1);
        chk("R8 det not yet set", {31'h0, det_flag}, 32'h0);
        @(negedge clk);
        chk("R5 hit is one cycle", {24'h0, hit_pulse}, 32'h0);
        chk("R8 det set after hit", {31'h0, det_flag}, 32'h1);
        chk("R9 pm not yet set", {31'h0, pm_status}, 32'h0);
        @(negedge clk);
        chk("R9 pm set after det", {31'h0, pm_status}, 32'h1);
        chk("R10 wake with enable", {31'h0, wake_out}, 32'h1);
        sb.push_back('{mask: 8'h20, tag: "R5 timing frame"});
        wake_en = 1'b0; #1;
        chk("R10 wake blocked", {31'h0, wake_out}, 32'h0);
        wake_en = 1'b1;
        det_clr = 1'b1; @(negedge clk); det_clr = 1'b0;
        chk("R8 det w1c", {31'h0, det_flag}, 32'h0);
        chk("R9 pm survives det clear", {31'h0, pm_status}, 32'h1);
        pm_clr = 1'b1; @(negedge clk); pm_clr = 1'b0;
        chk("R9 pm w1c", {31'h0, pm_status}, 32'h0);
        chk("R10 wake follows pm", {31'h0, wake_out}, 32'h0);
        repeat (3) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule